// File: doc/BRIEF.md
# Core Module System Control Register File

This block is the control and status register set of a processor core module. It sits on a simple 32-bit register bus with word addresses. It returns fixed identification and status words, and it holds the oscillator settings behind a 16-bit unlock key. A control register drives a memory-overlay enable and a status LED. Writing the control register can also raise a one-cycle system reset request. The block further holds two flag registers, each changed through a separate set address and clear address. A free-running reference counter runs off a prescaler. A small interrupt group combines external sources with a software source and applies separate IRQ and FIQ enables.

A read is captured on the clock edge where `bus_sel` is high and `bus_wr` is low. `bus_rdata` holds the captured value until the next read. A write takes effect on the edge where `bus_sel` and `bus_wr` are both high. A read-only presence window returns bytes from a table that the block computes from the fitted memory size. Actual clock generation, address remapping and supply control belong to other blocks. This block only exports the remap state and the reset request as plain signals.

Top module: `sysctl_regfile`

## Requirements
- R1: Word 0 reads 0x411A3001, word 4 reads 0x00100000 and word 1 reads zero. Any word without a register reads zero, and a write to it changes no register.
- R2: A write to word 5 stores bits 15:0 of the data. Reading word 5 returns 0x0001A05F while the stored key is 0xA05F, and returns the stored 16-bit value otherwise.
- R3: Word 2 resets to 0x01000048 and word 7 resets to 0x0007FEFF. A write to either takes effect only while the stored key is 0xA05F; otherwise the write is ignored.
- R4: A write to word 3 keeps data bits 0 and 2 and clears the other bits, so bit 3 always reads zero. A write with data bit 3 set raises `reset_req` for exactly one cycle, starting at the edge that takes the write.
- R5: `overlay_en` is high while control bit 2 is clear and low while it is set. `led_out` follows control bit 0. Both are low-latency: they change at the edge that takes the write.
- R6: Writing word 12 ORs the data into the flag register, and writing word 13 clears the bits set in the data. Word 12 reads the flags. Words 14 and 15 do the same for a second flag register, which reads at word 14.
- R7: Word 10 reads a 32-bit counter that is zero at reset and increases by one every PRESCALE clock cycles.
- R8: Words 64 to 95 read a presence table through bits 7:0, with the upper bits zero. The table holds entry 0 = 0x20, entry 1 = 0x01, entry 2 = 0x04 and entry 31 = the size byte; every other entry is zero. The size byte is 64, 32, 16, 4 or 2 for at least 256, 128, 64 or 32 MB, or less. Words 96 to 127 read zero.
- R9: Word 8 resets to 0x00011122 ORed with a size code (0x10, 0x0C, 0x08 or 0x04 for at least 256, 128, 64 or 32 MB, else 0). Word 9 resets to 0x00000112. Both take any written value.
- R10: Raw status (word 17) is `irq_src` ORed with the software bit in bit 0. Word 18 sets IRQ enable bits and reads them, and word 19 clears them. Word 16 reads raw AND enable, and `irq_out` is high when that value is nonzero. Enable bits at or above N_IRQ read zero.
- R11: Words 24 to 27 do the same for the FIQ enables and `fiq_out`: 24 is masked status, 25 is raw status, 26 sets the enables and 27 clears them.
- R12: Writing word 20 with data bit 0 set sets the software source, and writing word 21 with data bit 0 set clears it. Word 20 reads raw bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, captured at the read edge |
| irq_src | input | N_IRQ | External interrupt levels |
| irq_out | output | 1 | Any enabled IRQ source active |
| fiq_out | output | 1 | Any enabled FIQ source active |
| overlay_en | output | 1 | Boot-flash overlay enable, inverse of control bit 2 |
| led_out | output | 1 | Status LED, control bit 0 |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The lock is tried with three kinds of write: the exact key, the key with junk in the upper half, and a wrong key. Each is followed by an oscillator write, which shows whether the key is compared on the stored 16 bits only and whether the guard releases and re-engages.

The control register is written with all ones and then with zero. This separates the retained bits from the dropped ones, and a reset request that pulses from one that sticks.

The interrupt group runs the external pattern 0xA0 against overlapping and disjoint enables, with the software bit toggled in between. This shows the difference between raw and masked status, between the IRQ and FIQ paths, and whether enable bits above N_IRQ are cut off.

Flag set and clear writes use overlapping masks, to show OR-set apart from overwrite. The presence window is read at the populated entries, at an empty entry, and in the zero tail.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned WORD_W = 32;

   localparam int unsigned A_IDENT    = 0;
   localparam int unsigned A_PROC     = 1;
   localparam int unsigned A_OSC      = 2;
   localparam int unsigned A_CTRL     = 3;
   localparam int unsigned A_STAT     = 4;
   localparam int unsigned A_KEY      = 5;
   localparam int unsigned A_AUXOSC   = 7;
   localparam int unsigned A_SDRAM    = 8;
   localparam int unsigned A_INIT     = 9;
   localparam int unsigned A_REFCNT   = 10;
   localparam int unsigned A_FLAG_SET = 12;
   localparam int unsigned A_FLAG_CLR = 13;
   localparam int unsigned A_NVF_SET  = 14;
   localparam int unsigned A_NVF_CLR  = 15;
   localparam int unsigned A_IRQ_STAT = 16;
   localparam int unsigned A_IRQ_RAW  = 17;
   localparam int unsigned A_IRQ_ENS  = 18;
   localparam int unsigned A_IRQ_ENC  = 19;
   localparam int unsigned A_SOFT_SET = 20;
   localparam int unsigned A_SOFT_CLR = 21;
   localparam int unsigned A_FIQ_STAT = 24;
   localparam int unsigned A_FIQ_RAW  = 25;
   localparam int unsigned A_FIQ_ENS  = 26;
   localparam int unsigned A_FIQ_ENC  = 27;
   localparam int unsigned A_WIN_BASE = 64;
   localparam int unsigned WIN_LEN    = 32;

   localparam logic [31:0] IDENT_VAL   = 32'h411A_3001;
   localparam logic [31:0] STATUS_VAL  = 32'h0010_0000;
   localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;
   localparam logic [31:0] KEY_RD_VAL  = 32'h0001_A05F;
   localparam logic [31:0] OSC_RST     = 32'h0100_0048;
   localparam logic [31:0] AUXOSC_RST  = 32'h0007_FEFF;
   localparam logic [31:0] SDRAM_BASE  = 32'h0001_1122;
   localparam logic [31:0] INIT_RST    = 32'h0000_0112;

   typedef struct packed {
      logic led;
      logic remap;
   } ctrl_t;

   function automatic logic [31:0] sdram_code(input int unsigned mem_mb);
      if (mem_mb >= 256)      return 32'h10;
      else if (mem_mb >= 128) return 32'h0C;
      else if (mem_mb >= 64)  return 32'h08;
      else if (mem_mb >= 32)  return 32'h04;
      else                    return 32'h00;
   endfunction

   function automatic logic [7:0] size_byte(input int unsigned mem_mb);
      if (mem_mb >= 256)      return 8'd64;
      else if (mem_mb >= 128) return 8'd32;
      else if (mem_mb >= 64)  return 8'd16;
      else if (mem_mb >= 32)  return 8'd4;
      else                    return 8'd2;
   endfunction

   function automatic logic [7:0] presence_byte(input logic [4:0] idx,
                                                input int unsigned mem_mb);
      case (idx)
         5'd0:    return 8'h20;
         5'd1:    return 8'h01;
         5'd2:    return 8'h04;
         5'd31:   return size_byte(mem_mb);
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
   parameter int unsigned       W       = 32,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST_VAL;
      else if (set_we) q <= q | mask;
      else if (clr_we) q <= q & ~mask;
   end
endmodule

// File: rtl/sysctl_keyosc.sv
module sysctl_keyosc
   import sysctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_we,
   input  logic        osc_we,
   input  logic        aux_we,
   input  logic [31:0] wdata,
   output logic [15:0] key_q,
   output logic        unlocked,
   output logic [31:0] osc_q,
   output logic [31:0] aux_q
);
   assign unlocked = (key_q == UNLOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         osc_q <= OSC_RST;
         aux_q <= AUXOSC_RST;
      end else begin
         if (key_we)              key_q <= wdata[15:0];
         if (osc_we && unlocked)  osc_q <= wdata;
         if (aux_we && unlocked)  aux_q <= wdata;
      end
   end
endmodule

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
   parameter int unsigned PRESCALE = 4,
   parameter int unsigned CNT_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);
   logic tick;

   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned DIV_W = $clog2(PRESCALE);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);
         logic [DIV_W-1:0] div_q;
         assign tick = (div_q == DIV_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    div_q <= '0;
            else if (tick) div_q <= '0;
            else           div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (tick) count <= count + 1'b1;
   end
endmodule

// File: rtl/sysctl_intgrp.sv
module sysctl_intgrp #(
   parameter int unsigned N_IRQ = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] src,
   input  logic             irq_set_we,
   input  logic             irq_clr_we,
   input  logic             fiq_set_we,
   input  logic             fiq_clr_we,
   input  logic             soft_set_we,
   input  logic             soft_clr_we,
   input  logic [31:0]      wdata,
   output logic [N_IRQ-1:0] raw,
   output logic [N_IRQ-1:0] irq_en,
   output logic [N_IRQ-1:0] fiq_en,
   output logic             irq_out,
   output logic             fiq_out
);
   logic soft_q;

   sysctl_setclr #(.W(N_IRQ)) u_irq_en (
      .clk(clk), .rst_n(rst_n), .set_we(irq_set_we), .clr_we(irq_clr_we),
      .mask(wdata[N_IRQ-1:0]), .q(irq_en));

   sysctl_setclr #(.W(N_IRQ)) u_fiq_en (
      .clk(clk), .rst_n(rst_n), .set_we(fiq_set_we), .clr_we(fiq_clr_we),
      .mask(wdata[N_IRQ-1:0]), .q(fiq_en));

   sysctl_setclr #(.W(1)) u_soft (
      .clk(clk), .rst_n(rst_n),
      .set_we(soft_set_we && wdata[0]), .clr_we(soft_clr_we && wdata[0]),
      .mask(1'b1), .q(soft_q));

   assign raw     = src | {{(N_IRQ-1){1'b0}}, soft_q};
   assign irq_out = |(raw & irq_en);
   assign fiq_out = |(raw & fiq_en);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned N_IRQ    = 8,
   parameter int unsigned PRESCALE = 4,
   parameter int unsigned MEM_MB   = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [N_IRQ-1:0]  irq_src,
   output logic              irq_out,
   output logic              fiq_out,
   output logic              overlay_en,
   output logic              led_out,
   output logic              reset_req
);
   localparam logic [31:0] SDRAM_RST = SDRAM_BASE | sdram_code(MEM_MB);
   localparam int unsigned WIN_END   = A_WIN_BASE + WIN_LEN;

   generate
      if (ADDR_W < 7 || ADDR_W > 30) begin : g_bad_addr
         $error("sysctl_regfile: ADDR_W must lie in 7..30");
      end
      if (N_IRQ < 1 || N_IRQ > 32) begin : g_bad_nirq
         $error("sysctl_regfile: N_IRQ must lie in 1..32");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("sysctl_regfile: PRESCALE must be at least 1");
      end
   endgenerate

   logic wr_en, rd_en;
   assign wr_en = bus_sel &&  bus_wr;
   assign rd_en = bus_sel && !bus_wr;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned w);
      return a == ADDR_W'(w);
   endfunction

   // key and oscillators
   logic [15:0] key_q;
   logic        unlocked;
   logic [31:0] osc_q, aux_q;

   sysctl_keyosc u_keyosc (
      .clk(clk), .rst_n(rst_n),
      .key_we(wr_en && hit(bus_addr, A_KEY)),
      .osc_we(wr_en && hit(bus_addr, A_OSC)),
      .aux_we(wr_en && hit(bus_addr, A_AUXOSC)),
      .wdata(bus_wdata),
      .key_q(key_q), .unlocked(unlocked), .osc_q(osc_q), .aux_q(aux_q));

   // control, sdram, init
   ctrl_t       ctrl_q;
   logic [31:0] sdram_q, init_q;
   logic        rst_pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         sdram_q     <= SDRAM_RST;
         init_q      <= INIT_RST;
         rst_pulse_q <= 1'b0;
      end else begin
         rst_pulse_q <= wr_en && hit(bus_addr, A_CTRL) && bus_wdata[3];
         if (wr_en && hit(bus_addr, A_CTRL)) begin
            ctrl_q.led   <= bus_wdata[0];
            ctrl_q.remap <= bus_wdata[2];
         end
         if (wr_en && hit(bus_addr, A_SDRAM)) sdram_q <= bus_wdata;
         if (wr_en && hit(bus_addr, A_INIT))  init_q  <= bus_wdata;
      end
   end

   assign overlay_en = !ctrl_q.remap;
   assign led_out    = ctrl_q.led;
   assign reset_req  = rst_pulse_q;

   // flag registers
   logic [31:0] flags_q, nvflags_q;

   sysctl_setclr #(.W(32)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_en && hit(bus_addr, A_FLAG_SET)),
      .clr_we(wr_en && hit(bus_addr, A_FLAG_CLR)),
      .mask(bus_wdata), .q(flags_q));

   sysctl_setclr #(.W(32)) u_nvflags (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_en && hit(bus_addr, A_NVF_SET)),
      .clr_we(wr_en && hit(bus_addr, A_NVF_CLR)),
      .mask(bus_wdata), .q(nvflags_q));

   // reference counter
   logic [31:0] refcnt;

   sysctl_refcnt #(.PRESCALE(PRESCALE), .CNT_W(32)) u_refcnt (
      .clk(clk), .rst_n(rst_n), .count(refcnt));

   // interrupt group
   logic [N_IRQ-1:0] raw, irq_en, fiq_en;

   sysctl_intgrp #(.N_IRQ(N_IRQ)) u_intgrp (
      .clk(clk), .rst_n(rst_n), .src(irq_src),
      .irq_set_we (wr_en && hit(bus_addr, A_IRQ_ENS)),
      .irq_clr_we (wr_en && hit(bus_addr, A_IRQ_ENC)),
      .fiq_set_we (wr_en && hit(bus_addr, A_FIQ_ENS)),
      .fiq_clr_we (wr_en && hit(bus_addr, A_FIQ_ENC)),
      .soft_set_we(wr_en && hit(bus_addr, A_SOFT_SET)),
      .soft_clr_we(wr_en && hit(bus_addr, A_SOFT_CLR)),
      .wdata(bus_wdata),
      .raw(raw), .irq_en(irq_en), .fiq_en(fiq_en),
      .irq_out(irq_out), .fiq_out(fiq_out));

   // read multiplexer
   logic [31:0] raw32, irqen32, fiqen32;
   assign raw32   = 32'(raw);
   assign irqen32 = 32'(irq_en);
   assign fiqen32 = 32'(fiq_en);

   logic [31:0] rd_mux;
   logic [4:0]  win_idx;
   assign win_idx = 5'(bus_addr - ADDR_W'(A_WIN_BASE));

   always_comb begin
      rd_mux = '0;
      if (bus_addr >= ADDR_W'(A_WIN_BASE) && bus_addr < ADDR_W'(WIN_END)) begin
         rd_mux = {24'h0, presence_byte(win_idx, MEM_MB)};
      end else begin
         case (int'(bus_addr))
            A_IDENT:    rd_mux = IDENT_VAL;
            A_OSC:      rd_mux = osc_q;
            A_CTRL:     rd_mux = {29'h0, ctrl_q.remap, 1'b0, ctrl_q.led};
            A_STAT:     rd_mux = STATUS_VAL;
            A_KEY:      rd_mux = unlocked ? KEY_RD_VAL : {16'h0, key_q};
            A_AUXOSC:   rd_mux = aux_q;
            A_SDRAM:    rd_mux = sdram_q;
            A_INIT:     rd_mux = init_q;
            A_REFCNT:   rd_mux = refcnt;
            A_FLAG_SET: rd_mux = flags_q;
            A_NVF_SET:  rd_mux = nvflags_q;
            A_IRQ_STAT: rd_mux = raw32 & irqen32;
            A_IRQ_RAW:  rd_mux = raw32;
            A_IRQ_ENS:  rd_mux = irqen32;
            A_SOFT_SET: rd_mux = {31'h0, raw32[0]};
            A_FIQ_STAT: rd_mux = raw32 & fiqen32;
            A_FIQ_RAW:  rd_mux = raw32;
            A_FIQ_ENS:  rd_mux = fiqen32;
            default:    rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_IRQ  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              reset_req,
   input logic              overlay_en,
   input logic              irq_out,
   input logic [N_IRQ-1:0]  irq_en,
   input logic [15:0]       key_q,
   input logic [31:0]       osc_q,
   input logic [31:0]       aux_q
);
   AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(0)) |=> bus_rdata == 32'h411A_3001); // R1

   AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(6)) |=> bus_rdata == 32'h0); // R1

   AST_KEY_LOW16: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(5)) |=> key_q == $past(bus_wdata[15:0])); // R2

   AST_OSC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(2) && key_q != 16'hA05F) |=> $stable(osc_q)); // R3

   AST_AUX_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(7) && key_q != 16'hA05F) |=> $stable(aux_q)); // R3

   AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req); // R4

   AST_OVERLAY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(3)) |=> overlay_en == !$past(bus_wdata[2])); // R5

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq_out); // R10
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .reset_req(reset_req), .overlay_en(overlay_en), .irq_out(irq_out),
   .irq_en(irq_en), .key_q(key_q), .osc_q(osc_q), .aux_q(aux_q));

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned N_IRQ  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [N_IRQ-1:0]  irq_src = '0;
   logic              irq_out, fiq_out, overlay_en, led_out, reset_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sysctl_regfile #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ), .PRESCALE(1), .MEM_MB(128)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_src(irq_src), .irq_out(irq_out), .fiq_out(fiq_out),
      .overlay_en(overlay_en), .led_out(led_out), .reset_req(reset_req));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int unsigned a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int unsigned a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
      @(posedge clk); #2;
      d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int unsigned a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      check("R5 overlay at reset", 32'(overlay_en), 32'h1);
      check("R5 led at reset", 32'(led_out), 32'h0);
      check("R4 reset_req at reset", 32'(reset_req), 32'h0);
      rd_chk("R3 osc reset", 2, 32'h0100_0048);
      rd_chk("R3 aux reset", 7, 32'h0007_FEFF);
      rd_chk("R9 sdram reset", 8, 32'h0001_112E);
      rd_chk("R9 init reset", 9, 32'h0000_0112);
   endtask

   task automatic t_ident();
      rd_chk("R1 ident", 0, 32'h411A_3001);
      rd_chk("R1 proc", 1, 32'h0);
      rd_chk("R1 status", 4, 32'h0010_0000);
      rd_chk("R1 hole 6", 6, 32'h0);
      rd_chk("R1 hole 200", 200, 32'h0);
      wr(6, 32'hFFFF_FFFF);
      wr(0, 32'h1234_5678);
      wr(200, 32'hFFFF_FFFF);
      rd_chk("R1 ident after write", 0, 32'h411A_3001);
      rd_chk("R1 hole after write", 6, 32'h0);
      rd_chk("R1 flags untouched", 12, 32'h0);
      rd_chk("R1 sdram untouched", 8, 32'h0001_112E);
   endtask

   task automatic t_lock_osc();
      wr(2, 32'hDEAD_0001);
      rd_chk("R3 osc locked", 2, 32'h0100_0048);
      wr(5, 32'hFFFF_0042);
      rd_chk("R2 key low16", 5, 32'h0000_0042);
      wr(7, 32'hDEAD_0002);
      rd_chk("R3 aux locked", 7, 32'h0007_FEFF);
      wr(5, 32'h1234_A05F);
      rd_chk("R2 key unlocked read", 5, 32'h0001_A05F);
      wr(2, 32'hCAFE_0001);
      wr(7, 32'hCAFE_0002);
      rd_chk("R3 osc unlocked", 2, 32'hCAFE_0001);
      rd_chk("R3 aux unlocked", 7, 32'hCAFE_0002);
      wr(5, 32'h0000_A05E);
      rd_chk("R2 key relocked", 5, 32'h0000_A05E);
      wr(2, 32'h0);
      rd_chk("R3 osc relocked", 2, 32'hCAFE_0001);
   endtask

   task automatic t_ctrl();
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(3); bus_wdata = 32'hFFFF_FFFF;
      @(posedge clk); #2;
      check("R4 reset_req pulse", 32'(reset_req), 32'h1);
      check("R5 overlay off", 32'(overlay_en), 32'h0);
      check("R5 led on", 32'(led_out), 32'h1);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      @(posedge clk); #2;
      check("R4 reset_req one cycle", 32'(reset_req), 32'h0);
      rd_chk("R4 ctrl readback", 3, 32'h0000_0005);
      wr(3, 32'h0);
      check("R4 no pulse without bit3", 32'(reset_req), 32'h0);
      check("R5 overlay back on", 32'(overlay_en), 32'h1);
      check("R5 led off", 32'(led_out), 32'h0);
      rd_chk("R4 ctrl cleared", 3, 32'h0);
   endtask

   task automatic t_flags();
      wr(12, 32'h0000_00F0);
      wr(12, 32'h0000_0F00);
      rd_chk("R6 flags or-set", 12, 32'h0000_0FF0);
      wr(13, 32'h0000_0330);
      rd_chk("R6 flags clear", 12, 32'h0000_0CC0);
      wr(14, 32'h8000_0001);
      wr(15, 32'h0000_0001);
      rd_chk("R6 nvflags", 14, 32'h8000_0000);
      rd_chk("R6 flags independent", 12, 32'h0000_0CC0);
   endtask

   task automatic t_refcnt();
      logic [31:0] a, b, c;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(10);
      @(posedge clk); #2; a = bus_rdata;
      @(posedge clk); #2; b = bus_rdata;
      repeat (5) @(posedge clk);
      #2; c = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
      check("R7 refcnt step 1", b - a, 32'd1);
      check("R7 refcnt step 5", c - b, 32'd5);
   endtask

   task automatic t_window();
      rd_chk("R8 entry 0", 64, 32'h20);
      rd_chk("R8 entry 1", 65, 32'h01);
      rd_chk("R8 entry 2", 66, 32'h04);
      rd_chk("R8 entry 5 empty", 69, 32'h00);
      rd_chk("R8 entry 31 size", 95, 32'd32);
      rd_chk("R8 tail zero", 96, 32'h0);
      rd_chk("R8 tail end zero", 127, 32'h0);
      wr(8, 32'h1357_9BDF);
      wr(9, 32'h0000_0222);
      rd_chk("R9 sdram write", 8, 32'h1357_9BDF);
      rd_chk("R9 init write", 9, 32'h0000_0222);
   endtask

   task automatic t_irq();
      irq_src = 8'hA0;
      rd_chk("R10 raw", 17, 32'hA0);
      check("R10 irq idle", 32'(irq_out), 32'h0);
      wr(18, 32'hFFFF_FF30);
      rd_chk("R10 enable width", 18, 32'h30);
      wr(19, 32'h0000_0010);
      rd_chk("R10 enable clear", 18, 32'h20);
      rd_chk("R10 masked", 16, 32'h20);
      check("R10 irq asserted", 32'(irq_out), 32'h1);
      check("R11 fiq idle", 32'(fiq_out), 32'h0);
      wr(19, 32'h20);
      rd_chk("R10 masked after clear", 16, 32'h0);
      check("R10 irq dropped", 32'(irq_out), 32'h0);
   endtask

   task automatic t_fiq_soft();
      wr(26, 32'h0000_0003);
      rd_chk("R11 fiq enable", 26, 32'h03);
      rd_chk("R11 fiq masked none", 24, 32'h0);
      check("R11 fiq still idle", 32'(fiq_out), 32'h0);
      wr(20, 32'h1);
      rd_chk("R12 soft read", 20, 32'h1);
      rd_chk("R12 raw bit0", 25, 32'hA1);
      rd_chk("R11 fiq masked soft", 24, 32'h01);
      check("R11 fiq asserted", 32'(fiq_out), 32'h1);
      check("R10 irq ignores fiq enables", 32'(irq_out), 32'h0);
      wr(21, 32'h0);
      rd_chk("R12 clear needs bit0", 20, 32'h1);
      wr(21, 32'h1);
      rd_chk("R12 soft cleared", 20, 32'h0);
      check("R11 fiq dropped", 32'(fiq_out), 32'h0);
      wr(27, 32'h3);
      rd_chk("R11 fiq enable cleared", 26, 32'h0);
      irq_src = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ident();
      t_lock_osc();
      t_ctrl();
      t_flags();
      t_refcnt();
      t_window();
      t_irq();
      t_fiq_soft();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule